// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block holds the programming state of an interrupt router: one identification register, one version register, one arbitration register and a table of redirection entries, one per interrupt pin. Software never addresses these registers directly. It first writes a register index into a select register, then reads or writes the chosen register through a single 32-bit data window. Each redirection entry is 64 bits wide and is reached as two 32-bit halves. The layout is vector in bits 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote IRR in 14, trigger mode in 15 (1 = level, 0 = edge), mask in 16 and destination in 63:56.

The block checks the access width and the offset, protects the read-only status bits, and applies the side effect that a switch to edge trigger drops a pending remote IRR. Every entry is exported to the delivery logic as a flat bus. That logic reports back through per-pin remote-IRR set and clear inputs. When a write changes an entry in any field other than mask or polarity, the block raises a one-cycle change strobe that carries the pin number, so that the delivery side can recompute its trigger-mode tables.

Top module: `irq_redir_regfile`

## Requirements
- R1: Only accesses with size code 2 (4 bytes; codes 0, 1 and 3 mean 1, 2 and 8 bytes) at offset 0x00 or 0x10 are honoured. Every other access reads as 0 on `bus_rdata` and changes no state.
- R2: A write to offset 0x00 latches all 32 data bits as the index, and a read of offset 0x00 returns them. Only index bits 7:0 select the register behind the window at offset 0x10.
- R3: Index 0x00 selects identification, 0x01 version and 0x02 arbitration. Index 0x10+2n selects bits 31:0 of entry n and index 0x11+2n selects bits 63:32. Any other index reads as 0, and writes to it are ignored.
- R4: The version register reads ((N_ENT−1)<<16) | 0x11, which is 0x001F0011 for 32 entries.
- R5: The identification register keeps only data bits 27:24 and reads 0 in all other bits. The arbitration register reads the same value as identification. Writes to version and arbitration have no effect.
- R6: After reset, every entry holds 0x0001000000010000, and both the index and the identification register hold 0.
- R7: A write to an entry half replaces every bit of that half except delivery status (bit 12) and remote IRR (bit 14), which keep their values. The other half is unchanged. Delivery status is never set by the block.
- R8: When a write leaves an entry with trigger mode 0 (edge), that entry's remote IRR bit reads 0 from the next cycle on.
- R9: `irr_set[n]` sets remote IRR of entry n in the next cycle and `irr_clr[n]` clears it. Clear wins when both are high, and both apply after a same-cycle write.
- R10: In the cycle after an accepted entry write, `chg_valid` is high for exactly one cycle with `chg_pin` = n if any bit other than 13 or 16 of entry n differs from its value before the write. Otherwise `chg_valid` stays low.
- R11: `ent_flat[64n+63:64n]` always equals the current contents of entry n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code, log2 of the byte count |
| bus_addr | input | 8 | Offset inside the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irr_set | input | N_ENT | Per-pin remote-IRR set from the delivery logic |
| irr_clr | input | N_ENT | Per-pin remote-IRR clear from the delivery logic |
| ent_flat | output | 64*N_ENT | All entries, entry n in bits 64n+63:64n |
| chg_valid | output | 1 | One-cycle strobe for a changed entry |
| chg_pin | output | PIN_W | Pin number of the changed entry |

## Verification
The bench builds the block with the default 32 entries and a 4-bit identification field at bits 27:24. With these values, index 0x4F is the last entry half, 0x50 is the first index past the table, and the version reads 0x001F0011. The reference model tracks all 32 entries each clock, so writes to entry halves at the table boundaries and unchanged neighbours are both covered. Clashes between remote-IRR set and clear, and between a set and a same-cycle entry write, come up in both the directed and the random phases.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;

  localparam logic [7:0] IX_ID   = 8'h00;
  localparam logic [7:0] IX_VER  = 8'h01;
  localparam logic [7:0] IX_ARB  = 8'h02;
  localparam logic [7:0] IX_TBL  = 8'h10;

  localparam int unsigned B_DLS = 12;
  localparam int unsigned B_POL = 13;
  localparam int unsigned B_IRR = 14;
  localparam int unsigned B_TRG = 15;
  localparam int unsigned B_MSK = 16;

  localparam logic [63:0] ENTRY_RST = 64'h0001_0000_0001_0000;
  localparam logic [63:0] RO_BITS   = (64'd1 << B_DLS) | (64'd1 << B_IRR);
  localparam logic [63:0] QUIET     = (64'd1 << B_POL) | (64'd1 << B_MSK);

  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        trig;
    logic        rirr;
    logic        pol;
    logic        dstat;
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } entry_t;

  function automatic logic [63:0] merge_half(input logic [63:0] old,
                                             input logic [31:0] data,
                                             input logic hi);
    logic [63:0] wmask;
    logic [63:0] placed;
    wmask  = (hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF}) & ~RO_BITS;
    placed = hi ? {data, 32'h0} : {32'h0, data};
    return (old & ~wmask) | (placed & wmask);
  endfunction

  function automatic logic [31:0] version_word(input int unsigned n);
    return (32'(n - 1) << 16) | 32'h0000_0011;
  endfunction

  function automatic logic watched_diff(input logic [63:0] a, input logic [63:0] b);
    return |((a ^ b) & ~QUIET);
  endfunction

endpackage

// File: rtl/redir_window.sv
module redir_window
  import irq_redir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [1:0]  bus_size,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] idx_q,
  output logic        sel_rd,
  output logic        win_rd,
  output logic        win_wr
);

  logic ok;
  logic sel_hit;
  logic win_hit;

  assign ok      = bus_valid && (bus_size == SZ_WORD);
  assign sel_hit = ok && (bus_addr == OFF_SEL);
  assign win_hit = ok && (bus_addr == OFF_WIN);
  assign sel_rd  = sel_hit && !bus_write;
  assign win_rd  = win_hit && !bus_write;
  assign win_wr  = win_hit && bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (sel_hit && bus_write)
      idx_q <= bus_wdata;
  end

endmodule

// File: rtl/redir_entry.sv
module redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [31:0] wr_data,
  input  logic        irr_set,
  input  logic        irr_clr,
  output logic [63:0] word_q,
  output logic        changed
);

  logic [63:0] wr_word;
  logic [63:0] base;
  logic [63:0] nxt;

  always_comb begin
    wr_word = merge_half(word_q, wr_data, wr_hi);
    if (!wr_word[B_TRG])
      wr_word[B_IRR] = 1'b0;
    base = wr_en ? wr_word : word_q;
    nxt  = base;
    if (irr_clr)
      nxt[B_IRR] = 1'b0;
    else if (irr_set)
      nxt[B_IRR] = 1'b1;
  end

  assign changed = wr_en && watched_diff(word_q, wr_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= ENTRY_RST;
    else
      word_q <= nxt;
  end

endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENT  = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ID_LSB = 24,
  parameter int unsigned PIN_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [1:0]           bus_size,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [N_ENT-1:0]     irr_set,
  input  logic [N_ENT-1:0]     irr_clr,
  output logic [N_ENT*64-1:0]  ent_flat,
  output logic                 chg_valid,
  output logic [PIN_W-1:0]     chg_pin
);

  localparam int unsigned ENT_END = 16 + 2 * N_ENT;
  localparam logic [31:0] VER_VAL = version_word(N_ENT);

  logic [31:0]      idx_q;
  logic             sel_rd;
  logic             win_rd;
  logic             win_wr;
  logic [7:0]       reg_sel;
  logic [8:0]       rel;
  logic             is_ent;
  logic [PIN_W-1:0] ent_n;
  logic             ent_hi;
  logic [N_ENT-1:0] ent_wr;
  logic [N_ENT-1:0] ent_chg;
  logic [63:0]      ent_q [N_ENT];
  logic [ID_W-1:0]  id_q;
  logic [31:0]      id_word;
  logic [31:0]      win_val;
  logic [PIN_W-1:0] pin_enc;

  redir_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .idx_q     (idx_q),
    .sel_rd    (sel_rd),
    .win_rd    (win_rd),
    .win_wr    (win_wr)
  );

  assign reg_sel = idx_q[7:0];
  assign rel     = {1'b0, reg_sel} - {1'b0, IX_TBL};
  assign is_ent  = (reg_sel >= IX_TBL) && ({1'b0, reg_sel} < 9'(ENT_END));
  assign ent_n   = rel[PIN_W:1];
  assign ent_hi  = rel[0];

  for (genvar n = 0; n < N_ENT; n++) begin : g_ent
    assign ent_wr[n] = win_wr && is_ent && (ent_n == PIN_W'(n));

    redir_entry u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ent_wr[n]),
      .wr_hi   (ent_hi),
      .wr_data (bus_wdata),
      .irr_set (irr_set[n]),
      .irr_clr (irr_clr[n]),
      .word_q  (ent_q[n]),
      .changed (ent_chg[n])
    );

    assign ent_flat[64*n +: 64] = ent_q[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      id_q <= '0;
    else if (win_wr && (reg_sel == IX_ID))
      id_q <= bus_wdata[ID_LSB +: ID_W];
  end

  always_comb begin
    id_word = '0;
    id_word[ID_LSB +: ID_W] = id_q;
  end

  always_comb begin
    win_val = '0;
    if (is_ent)
      win_val = ent_hi ? ent_q[ent_n][63:32] : ent_q[ent_n][31:0];
    else if (reg_sel == IX_ID || reg_sel == IX_ARB)
      win_val = id_word;
    else if (reg_sel == IX_VER)
      win_val = VER_VAL;
  end

  assign bus_rdata = sel_rd ? idx_q : (win_rd ? win_val : 32'h0);

  always_comb begin
    pin_enc = '0;
    for (int i = 0; i < N_ENT; i++)
      if (ent_chg[i])
        pin_enc = PIN_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_valid <= 1'b0;
      chg_pin   <= '0;
    end else begin
      chg_valid <= |ent_chg;
      chg_pin   <= pin_enc;
    end
  end

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENT = 32,
  parameter int unsigned PIN_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [1:0]          bus_size,
  input logic [7:0]          bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [31:0]         idx_q,
  input logic [N_ENT-1:0]    irr_set,
  input logic [N_ENT-1:0]    irr_clr,
  input logic [N_ENT-1:0]    ent_wr,
  input logic [N_ENT*64-1:0] ent_flat,
  input logic                chg_valid
);

  p_bad_size_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_size != SZ_WORD) |-> (bus_rdata == 32'h0));

  p_version_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_size == SZ_WORD && bus_addr == OFF_WIN &&
     idx_q[7:0] == IX_VER) |-> (bus_rdata == version_word(N_ENT)));

  p_chg_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> $past(|ent_wr));

  for (genvar n = 0; n < N_ENT; n++) begin : g_chk
    p_dstat_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ent_wr[n] |=> (ent_flat[64*n + B_DLS] == $past(ent_flat[64*n + B_DLS])));

    p_edge_drops_irr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_wr[n] && !irr_set[n]) |=> !(!ent_flat[64*n + B_TRG] && ent_flat[64*n + B_IRR]));

    p_irr_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irr_clr[n] |=> !ent_flat[64*n + B_IRR]);

    p_irr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_set[n] && !irr_clr[n]) |=> ent_flat[64*n + B_IRR]);
  end

endmodule

bind irq_redir_regfile irq_redir_chk #(.N_ENT(N_ENT), .PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .idx_q     (idx_q),
  .irr_set   (irr_set),
  .irr_clr   (irr_clr),
  .ent_wr    (ent_wr),
  .ent_flat  (ent_flat),
  .chg_valid (chg_valid)
);

// File: tb/tb_irq_redir_regfile.sv
module tb_irq_redir_regfile;

  localparam int N  = 32;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [1:0]    bus_size = 2'd2;
  logic [7:0]    bus_addr = 8'h0;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irr_set = '0;
  logic [N-1:0]  irr_clr = '0;
  logic [N*64-1:0] ent_flat;
  logic          chg_valid;
  logic [PW-1:0] chg_pin;

  int vectors = 0;
  int misses  = 0;
  bit go = 0;

  always #2 clk = ~clk;

  irq_redir_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irr_set(irr_set), .irr_clr(irr_clr),
    .ent_flat(ent_flat), .chg_valid(chg_valid), .chg_pin(chg_pin)
  );

  // behavioural reference model
  logic [63:0] m_ent [N];
  logic [31:0] m_idx;
  logic [3:0]  m_id;
  bit          m_chg;
  int          m_pin;

  function automatic logic [31:0] model_read(logic [1:0] sz, logic [7:0] ad);
    int r;
    if (sz != 2'd2) return 0;
    if (ad == 8'h00) return m_idx;
    if (ad != 8'h10) return 0;
    r = int'(m_idx & 32'hFF);
    if (r == 0 || r == 2) return {4'h0, m_id, 24'h0};
    if (r == 1) return 32'((N - 1) * 65536 + 17);
    if (r >= 16 && r < 16 + 2 * N) begin
      if (r % 2 == 1) return m_ent[(r - 16) / 2][63:32];
      return m_ent[(r - 16) / 2][31:0];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_ent[i] = 64'h0001000000010000;
      m_idx = 0; m_id = 0; m_chg = 0; m_pin = 0;
    end else begin
      m_chg = 0;
      if (bus_valid && bus_write && bus_size == 2'd2) begin
        if (bus_addr == 8'h00) m_idx = bus_wdata;
        else if (bus_addr == 8'h10) begin
          int r;
          r = int'(m_idx & 32'hFF);
          if (r == 0) m_id = bus_wdata[27:24];
          else if (r >= 16 && r < 16 + 2 * N) begin
            int p, sh;
            logic [63:0] old, fld, nw;
            p   = (r - 16) / 2;
            sh  = (r % 2) * 32;
            old = m_ent[p];
            fld = (64'hFFFF_FFFF << sh) & ~64'h5000;
            nw  = (old & ~fld) | ((64'(bus_wdata) << sh) & fld);
            if (nw[15] == 1'b0) nw[14] = 1'b0;
            m_ent[p] = nw;
            if (((old ^ nw) & ~64'h12000) != 0) begin
              m_chg = 1; m_pin = p;
            end
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (irr_clr[i]) m_ent[i][14] = 1'b0;
        else if (irr_set[i]) m_ent[i][14] = 1'b1;
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (go) begin
      bit bad;
      bad = 0;
      vectors++;
      for (int i = 0; i < N; i++)
        if (ent_flat[64*i +: 64] !== m_ent[i] && !bad) begin
          bad = 1;
          $display("FAIL R11 entry %0d actual %h expected %h", i, ent_flat[64*i +: 64], m_ent[i]);
        end
      if (chg_valid !== m_chg || (m_chg && int'(chg_pin) != m_pin)) begin
        if (!bad) $display("FAIL R10 chg actual %b/%0d expected %b/%0d", chg_valid, chg_pin, m_chg, m_pin);
        bad = 1;
      end
      if (bus_valid && !bus_write) begin
        logic [31:0] ex;
        ex = model_read(bus_size, bus_addr);
        if (bus_rdata !== ex) begin
          if (!bad) $display("FAIL R3 read actual %h expected %h", bus_rdata, ex);
          bad = 1;
        end
      end
      if (bad) misses++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start();
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0; bus_size = 2'd2; irr_set = '0; irr_clr = '0;
  endtask

  task automatic wr(logic [1:0] sz, logic [7:0] ad, logic [31:0] d);
    start();
    bus_valid = 1; bus_write = 1; bus_size = sz; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(logic [1:0] sz, logic [7:0] ad, output logic [31:0] d);
    start();
    bus_valid = 1; bus_write = 0; bus_size = sz; bus_addr = ad;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic irr(logic [N-1:0] s, logic [N-1:0] c);
    start();
    irr_set = s; irr_clr = c;
    @(negedge clk);
  endtask

  task automatic wreg(logic [7:0] ix, logic [31:0] d);
    wr(2'd2, 8'h00, {24'h0, ix});
    wr(2'd2, 8'h10, d);
  endtask

  task automatic rreg(logic [7:0] ix, output logic [31:0] d);
    wr(2'd2, 8'h00, {24'h0, ix});
    rd(2'd2, 8'h10, d);
  endtask

  initial begin
    #800000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    go = 1;

    // R6 reset state
    rd(2'd2, 8'h00, v);      check("R6 index reset", v, 32'h0);
    rreg(8'h10, v);          check("R6 entry0 low", v, 32'h0001_0000);
    rreg(8'h11, v);          check("R6 entry0 high", v, 32'h0001_0000);
    rreg(8'h00, v);          check("R6 id reset", v, 32'h0);
    check("R11 entry0 export", ent_flat[31:0], 32'h0001_0000);

    // R4 version
    rreg(8'h01, v);          check("R4 version", v, 32'h001F_0011);

    // R5 identification and arbitration
    wreg(8'h00, 32'hFFFF_FFFF);
    rd(2'd2, 8'h10, v);      check("R5 id bits", v, 32'h0F00_0000);
    rreg(8'h02, v);          check("R5 arb mirrors id", v, 32'h0F00_0000);
    wr(2'd2, 8'h10, 32'h0);
    rreg(8'h00, v);          check("R5 arb write ignored", v, 32'h0F00_0000);
    wreg(8'h01, 32'h0);
    rd(2'd2, 8'h10, v);      check("R5 version write ignored", v, 32'h001F_0011);

    // R1 access rules
    wr(2'd1, 8'h00, 32'h55);
    rd(2'd2, 8'h00, v);      check("R1 narrow write dropped", v, 32'h01);
    rd(2'd3, 8'h10, v);      check("R1 wide read zero", v, 32'h0);
    rd(2'd2, 8'h04, v);      check("R1 bad offset read zero", v, 32'h0);
    wr(2'd2, 8'h14, 32'hDEAD_BEEF);
    rd(2'd2, 8'h00, v);      check("R1 bad offset write dropped", v, 32'h01);

    // R2 full index latched, low byte decodes
    wr(2'd2, 8'h00, 32'hABCD_0001);
    rd(2'd2, 8'h00, v);      check("R2 index readback", v, 32'hABCD_0001);
    rd(2'd2, 8'h10, v);      check("R2 low byte decode", v, 32'h001F_0011);

    // R3 undefined indices
    rreg(8'h05, v);          check("R3 hole reads zero", v, 32'h0);
    wreg(8'h50, 32'hFFFF_FFFF);
    rd(2'd2, 8'h10, v);      check("R3 past table reads zero", v, 32'h0);

    // R7 read-only bits, R10 strobe
    wreg(8'h16, 32'h0000_F0A5);
    rd(2'd2, 8'h10, v);      check("R7 ro bits kept", v, 32'h0000_A0A5);
    check("R10 strobe on change", {31'h0, chg_valid}, 32'h1);
    check("R10 strobe pin", {27'h0, chg_pin}, 32'd3);

    // R9 set, then R7 write keeps irr, R10 quiet change
    irr(32'h8, 32'h0);
    rd(2'd2, 8'h10, v);      check("R9 set irr", v, 32'h0000_E0A5);
    wr(2'd2, 8'h10, 32'h0000_80A5);
    rd(2'd2, 8'h10, v);      check("R7 irr kept over write", v, 32'h0000_C0A5);
    check("R10 polarity-only no strobe", {31'h0, chg_valid}, 32'h0);

    // R8 edge switch clears irr
    wr(2'd2, 8'h10, 32'h0000_00A5);
    rd(2'd2, 8'h10, v);      check("R8 edge clears irr", v, 32'h0000_00A5);

    // R9 clear beats set
    wreg(8'h1A, 32'h0000_8000);
    irr(32'h20, 32'h20);
    rd(2'd2, 8'h10, v);      check("R9 clear wins", v, 32'h0000_8000);
    irr(32'h20, 32'h0);
    rd(2'd2, 8'h10, v);      check("R9 set pin5", v, 32'h0000_C000);
    irr(32'h0, 32'h20);
    rd(2'd2, 8'h10, v);      check("R9 clear pin5", v, 32'h0000_8000);

    // R11 last entry high half
    wreg(8'h4F, 32'hAB00_0000);
    rd(2'd2, 8'h10, v);      check("R11 last high half", v, 32'hAB00_0000);
    check("R11 export dest", {24'h0, ent_flat[31*64+56 +: 8]}, 32'hAB);

    // random phase, compared every clock by the model
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: wr(2'd2, 8'h00, {24'h0, 8'($urandom_range(0, 84))});
        2, 3: wr(2'd2, 8'h10, $urandom);
        4, 5: rd(2'd2, 8'h10, v);
        6:    rd(2'($urandom_range(0, 3)), 8'($urandom_range(0, 31)), v);
        7:    wr(2'($urandom_range(0, 3)), 8'($urandom_range(0, 31)), $urandom);
        8:    irr(N'(1) << $urandom_range(0, N - 1), N'(1) << $urandom_range(0, N - 1));
        default: begin
          start();
          bus_valid = 1; bus_write = 1; bus_addr = 8'h10; bus_wdata = $urandom;
          irr_set = N'($urandom);
          @(negedge clk);
        end
      endcase
    end
    start();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule